// File: doc/BRIEF.md
# TDM DRAM Command Arbiter

This block shares one DRAM channel among a fixed number of requestors by cutting time into equal slots of `SLOT_LEN` cycles. Each slot belongs to one requestor, and ownership rotates in round-robin order. When a slot opens and its owner has a request waiting, the block serves the oldest one. It issues a precharge, then an activate, then a read or write column command, each at a fixed cycle offset inside the slot. Every other cycle carries a NOP with all request fields at zero.

The slot length and the fixed offsets are chosen so that every DRAM spacing rule holds by construction. These rules are precharge-to-activate, activate-to-column, row active time, row cycle, activate-to-activate, column-to-column, the two read/write turnarounds and the four-activate window. Nothing is checked per command at run time. Instead, the design fails at elaboration if the parameter set cannot meet the slot-length inequalities.

The block assumes a private bank mapping: a given bank is only ever addressed by one requestor. Each requestor has its own queue, and a request enters its queue in the cycle it is presented. Each served request is stamped with the cycle in which it arrived.

Top module: `tdm_cmd_arbiter`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `cmd_o` is NOP and every `cmd_*` field output is zero.
- R2: Slots are `SLOT_LEN` cycles long. The first slot starts in the first cycle after reset release, and slot k is owned by requestor k mod `NUM_REQ`, so requestor 0 owns the first slot. A served request's commands carry the owner's number on `cmd_id_o`.
- R3: In a slot whose owner has been handed a request, the commands are issued at these offsets from the slot start: PRE at offset 0, ACT at `T_RP+1`, and the column command at `T_RP+T_RCD+2`. All three carry the same request's id, date, kind, bank group, bank and row.
- R4: In every other cycle `cmd_o` is NOP and all field outputs are zero. This includes the whole of any slot whose owner had nothing eligible.
- R5: Each requestor's requests are served in arrival order, with one request per slot owned by that requestor.
- R6: A request is accepted in the cycle `req_valid_i` is high, in any state. It is served in the first slot of its requestor that starts at least two cycles after its arrival cycle. A request that arrives in the last cycle before such a slot waits for that requestor's following slot.
- R7: A request whose `req_id_i` is `NUM_REQ` or above is discarded. So is a request for a requestor whose queue already holds `FIFO_DEPTH` entries. Neither produces any command.
- R8: `cmd_date_o` gives the request's arrival cycle, modulo 2^`DATE_W`. The first cycle after reset release counts as cycle 0.
- R9: Encodings are as follows. `cmd_o` is 0 for NOP, 1 for PRE, 2 for ACT, 3 for RD and 4 for WR. `req_wr_i` is 1 for a write and 0 for a read. The column command is WR exactly when the request is a write.
- R10: Under a private bank mapping and the default parameters, the issued trace meets every spacing rule, each measured in cycles between the two commands:
  - PRE to ACT on the same bank: at least `T_RP`.
  - ACT to column on the same bank: at least `T_RCD`.
  - ACT to PRE on the same bank: at least `T_RAS`.
  - ACT to ACT on the same bank: at least `T_RC`.
  - ACT to ACT on any two banks: at least `T_RRD_L`.
  - Column to column: at least `T_CCD_L`.
  - WR to RD: at least `T_WTR_L+T_WL+T_BURST`.
  - RD to WR: at least `T_RTW`.
  - Four-activate window: no four ACTs within `T_FAW` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_id_i | input | ID_W | Requestor number |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_bg_i | input | BG_W | Bank group |
| req_bank_i | input | BANK_W | Bank |
| req_row_i | input | ROW_W | Row |
| cmd_o | output | 3 | Command code |
| cmd_id_o | output | ID_W | Requestor of the served request |
| cmd_date_o | output | DATE_W | Arrival cycle of the served request |
| cmd_wr_o | output | 1 | Kind of the served request |
| cmd_bg_o | output | BG_W | Bank group of the served request |
| cmd_bank_o | output | BANK_W | Bank of the served request |
| cmd_row_o | output | ROW_W | Row of the served request |

## Verification
Every command is due at a cycle that can be worked out from the request's arrival cycle alone. The serving slot is the first one of that requestor starting at least two cycles after arrival. Within that slot, PRE is due at offset 0, ACT at offset 5 and the column command at offset 8.

The bench counts cycles from reset release and samples at the falling edge. It logs every non-NOP command with its cycle index. After waiting past the column offset of each expected slot, it looks up the exact cycle in the log. Slots that must stay empty are checked over their full span, and spacing rules are checked over the whole log at the end.

// File: rtl/tdm_arb_pkg.sv
package tdm_arb_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_PRE = 3'd1,
    CMD_ACT = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } cmd_e;
endpackage

// File: rtl/tdm_req_fifo.sv
module tdm_req_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= ptr_inc(wr_q);
      if (do_pop)  rd_q <= ptr_inc(rd_q);
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end
endmodule

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int unsigned SLOT_LEN = 16,
  parameter int unsigned NUM_REQ  = 3,
  parameter int unsigned CNT_W    = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1,
  parameter int unsigned ID_W     = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic [ID_W-1:0]  owner_o,
  output logic [ID_W-1:0]  next_owner_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [ID_W-1:0]  owner_q;

  assign cnt_o        = cnt_q;
  assign owner_o      = owner_q;
  assign wrap_o       = (cnt_q == CNT_W'(SLOT_LEN - 1));
  assign next_owner_o = (owner_q == ID_W'(NUM_REQ - 1)) ? '0 : owner_q + ID_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      owner_q <= '0;
    end else if (wrap_o) begin
      cnt_q   <= '0;
      owner_q <= next_owner_o;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/tdm_cmd_arbiter.sv
module tdm_cmd_arbiter
  import tdm_arb_pkg::*;
#(
  parameter int unsigned NUM_REQ    = 3,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned BG_W       = 1,
  parameter int unsigned BANK_W     = 2,
  parameter int unsigned ROW_W      = 8,
  parameter int unsigned DATE_W     = 16,
  parameter int unsigned SLOT_LEN   = 16,
  parameter int unsigned T_RP       = 4,
  parameter int unsigned T_RCD      = 2,
  parameter int unsigned T_RAS      = 4,
  parameter int unsigned T_RC       = 3,
  parameter int unsigned T_RRD_L    = 3,
  parameter int unsigned T_RTW      = 10,
  parameter int unsigned T_CCD_L    = 12,
  parameter int unsigned T_WTR_L    = 10,
  parameter int unsigned T_WL       = 1,
  parameter int unsigned T_BURST    = 1,
  parameter int unsigned T_FAW      = 20,
  parameter int unsigned ID_W       = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ID_W-1:0]   req_id_i,
  input  logic              req_wr_i,
  input  logic [BG_W-1:0]   req_bg_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  output logic [2:0]        cmd_o,
  output logic [ID_W-1:0]   cmd_id_o,
  output logic [DATE_W-1:0] cmd_date_o,
  output logic              cmd_wr_o,
  output logic [BG_W-1:0]   cmd_bg_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_row_o
);
  localparam int unsigned CNT_W    = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
  localparam int unsigned ACT_DATE = T_RP + 1;
  localparam int unsigned COL_DATE = ACT_DATE + T_RCD + 1;
  localparam int unsigned ENT_W    = DATE_W + 1 + BG_W + BANK_W + ROW_W;

  typedef struct packed {
    logic [DATE_W-1:0] date;
    logic              wr;
    logic [BG_W-1:0]   bg;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
  } entry_t;

  // slot length must cover every spacing rule so fixed offsets are legal
  if (SLOT_LEN <= T_RC || SLOT_LEN <= T_RRD_L || SLOT_LEN <= T_RTW ||
      SLOT_LEN <= T_CCD_L || SLOT_LEN <= T_RP + 1 + T_RAS ||
      SLOT_LEN <= T_WTR_L + T_WL + T_BURST || 3 * SLOT_LEN <= T_FAW ||
      COL_DATE >= SLOT_LEN || ENT_W == 0) begin : g_bad_cfg
    $error("tdm_cmd_arbiter: slot length does not cover the timing set");
  end

  logic [CNT_W-1:0]   slot_cnt;
  logic [ID_W-1:0]    owner, next_owner;
  logic               slot_wrap;
  logic [NUM_REQ-1:0] push, pop, empty, full;
  entry_t             head [NUM_REQ];
  entry_t             in_ent, cur_q;
  logic               running_q;
  logic [DATE_W-1:0]  now_q;
  cmd_e               cmd;
  logic               live;

  tdm_slot_timer #(
    .SLOT_LEN(SLOT_LEN), .NUM_REQ(NUM_REQ), .CNT_W(CNT_W), .ID_W(ID_W)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_o(slot_cnt), .owner_o(owner),
    .next_owner_o(next_owner), .wrap_o(slot_wrap)
  );

  assign in_ent = '{date: now_q, wr: req_wr_i, bg: req_bg_i, bank: req_bank_i, row: req_row_i};

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
    assign push[g] = req_valid_i && (req_id_i == ID_W'(g));
    assign pop[g]  = slot_wrap && (next_owner == ID_W'(g)) && !empty[g];
    tdm_req_fifo #(.WIDTH(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push[g]), .pop_i(pop[g]),
      .data_i(in_ent), .data_o(head[g]), .empty_o(empty[g]), .full_o(full[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      cur_q     <= '0;
      now_q     <= '0;
    end else begin
      now_q <= now_q + DATE_W'(1);
      if (slot_wrap) begin
        running_q <= !empty[next_owner];
        if (!empty[next_owner]) cur_q <= head[next_owner];
      end
    end
  end

  always_comb begin
    cmd = CMD_NOP;
    if (running_q) begin
      if (slot_cnt == '0)                     cmd = CMD_PRE;
      else if (slot_cnt == CNT_W'(ACT_DATE))  cmd = CMD_ACT;
      else if (slot_cnt == CNT_W'(COL_DATE))  cmd = cur_q.wr ? CMD_WR : CMD_RD;
    end
  end

  assign live       = (cmd != CMD_NOP);
  assign cmd_o      = cmd;
  assign cmd_id_o   = live ? owner      : '0;
  assign cmd_date_o = live ? cur_q.date : '0;
  assign cmd_wr_o   = live && cur_q.wr;
  assign cmd_bg_o   = live ? cur_q.bg   : '0;
  assign cmd_bank_o = live ? cur_q.bank : '0;
  assign cmd_row_o  = live ? cur_q.row  : '0;
endmodule

// File: rtl/tdm_cmd_arbiter_chk.sv
module tdm_cmd_arbiter_chk #(
  parameter int unsigned ID_W     = 2,
  parameter int unsigned DATE_W   = 16,
  parameter int unsigned BG_W     = 1,
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned ROW_W    = 8,
  parameter int unsigned SLOT_LEN = 16,
  parameter int unsigned T_RP     = 4,
  parameter int unsigned T_RCD    = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        cmd_i,
  input logic [ID_W-1:0]   id_i,
  input logic [DATE_W-1:0] date_i,
  input logic              wr_i,
  input logic [BG_W-1:0]   bg_i,
  input logic [BANK_W-1:0] bank_i,
  input logic [ROW_W-1:0]  row_i
);
  localparam int unsigned ACT_DATE = T_RP + 1;
  localparam int unsigned COL_DATE = ACT_DATE + T_RCD + 1;
  localparam int unsigned GAP_W    = $clog2(SLOT_LEN + 1);
  localparam int unsigned FLD_W    = ID_W + DATE_W + 1 + BG_W + BANK_W + ROW_W;

  logic [FLD_W-1:0] fld, fld_q;
  logic [GAP_W-1:0] since_q;
  logic             seen_q;
  logic             is_col;

  assign fld    = {id_i, date_i, wr_i, bg_i, bank_i, row_i};
  assign is_col = (cmd_i == 3'd3) || (cmd_i == 3'd4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
      seen_q  <= 1'b0;
      fld_q   <= '0;
    end else if (cmd_i == 3'd1) begin
      since_q <= GAP_W'(1);
      seen_q  <= 1'b1;
      fld_q   <= fld;
    end else if (since_q != GAP_W'(SLOT_LEN)) begin
      since_q <= since_q + GAP_W'(1);
    end
  end

  AST_NOP_NULL:    assert property (@(posedge clk_i) disable iff (!rst_ni) (cmd_i == 3'd0) |-> (fld == '0)); // R4
  AST_CMD_CODE:    assert property (@(posedge clk_i) disable iff (!rst_ni) cmd_i <= 3'd4); // R9
  AST_ACT_OFFSET:  assert property (@(posedge clk_i) disable iff (!rst_ni) (cmd_i == 3'd2) |-> (seen_q && since_q == GAP_W'(ACT_DATE))); // R3
  AST_COL_OFFSET:  assert property (@(posedge clk_i) disable iff (!rst_ni) is_col |-> (seen_q && since_q == GAP_W'(COL_DATE))); // R3
  AST_SAME_REQ:    assert property (@(posedge clk_i) disable iff (!rst_ni) ((cmd_i == 3'd2) || is_col) |-> (fld == fld_q)); // R3
  AST_SLOT_GAP:    assert property (@(posedge clk_i) disable iff (!rst_ni) ((cmd_i == 3'd1) && seen_q) |-> (since_q == GAP_W'(SLOT_LEN))); // R2
  AST_COL_KIND:    assert property (@(posedge clk_i) disable iff (!rst_ni) is_col |-> (wr_i == (cmd_i == 3'd4))); // R9
endmodule

bind tdm_cmd_arbiter tdm_cmd_arbiter_chk #(
  .ID_W(ID_W), .DATE_W(DATE_W), .BG_W(BG_W), .BANK_W(BANK_W), .ROW_W(ROW_W),
  .SLOT_LEN(SLOT_LEN), .T_RP(T_RP), .T_RCD(T_RCD)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd_o), .id_i(cmd_id_o),
  .date_i(cmd_date_o), .wr_i(cmd_wr_o), .bg_i(cmd_bg_o), .bank_i(cmd_bank_o),
  .row_i(cmd_row_o)
);

// File: tb/tdm_cmd_arbiter_tb.sv
module tdm_cmd_arbiter_tb;
  localparam int NREQ = 3, DEPTH = 4, SL = 16;
  localparam int TRP = 4, TRCD = 2, TRAS = 4, TRC = 3, TRRD = 3, TRTW = 10;
  localparam int TCCD = 12, TWTR = 10, TWL = 1, TBURST = 1, TFAW = 20;
  localparam int ACTD = TRP + 1, COLD = ACTD + TRCD + 1, PER = SL * NREQ;
  localparam int LOGN = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       req_valid = 1'b0, req_wr = 1'b0;
  logic [1:0] req_id = '0, req_bank = '0;
  logic       req_bg = 1'b0;
  logic [7:0] req_row = '0;
  logic [2:0] cmd;
  logic [1:0] c_id, c_bank;
  logic [15:0] c_date;
  logic       c_wr, c_bg;
  logic [7:0] c_row;

  tdm_cmd_arbiter #(
    .NUM_REQ(NREQ), .FIFO_DEPTH(DEPTH), .BG_W(1), .BANK_W(2), .ROW_W(8), .DATE_W(16),
    .SLOT_LEN(SL), .T_RP(TRP), .T_RCD(TRCD), .T_RAS(TRAS), .T_RC(TRC), .T_RRD_L(TRRD),
    .T_RTW(TRTW), .T_CCD_L(TCCD), .T_WTR_L(TWTR), .T_WL(TWL), .T_BURST(TBURST), .T_FAW(TFAW)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_id_i(req_id),
    .req_wr_i(req_wr), .req_bg_i(req_bg), .req_bank_i(req_bank), .req_row_i(req_row),
    .cmd_o(cmd), .cmd_id_o(c_id), .cmd_date_o(c_date), .cmd_wr_o(c_wr),
    .cmd_bg_o(c_bg), .cmd_bank_o(c_bank), .cmd_row_o(c_row)
  );

  int cyc;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  int checks = 0, fails = 0, nop_bad = 0, l_n = 0;
  bit done = 0;
  int l_cyc [LOGN];
  int l_cmd [LOGN];
  int l_fld [LOGN];
  int l_bk  [LOGN];

  function automatic int pack(int id, int date, int wr, int bg, int bank, int row);
    return (id << 28) | (date << 12) | (wr << 11) | (bg << 10) | (bank << 8) | row;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd == 3'd0) begin
        if ({c_id, c_date, c_wr, c_bg, c_bank, c_row} != '0) nop_bad++;
      end else if (l_n < LOGN) begin
        l_cyc[l_n] = cyc;
        l_cmd[l_n] = int'(cmd);
        l_fld[l_n] = pack(int'(c_id), int'(c_date), int'(c_wr), int'(c_bg), int'(c_bank), int'(c_row));
        l_bk[l_n]  = {c_bg, c_bank};
        l_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic push(input int id, input int wr, input int bg, input int bank, input int row, output int at);
    req_valid = 1'b1; req_id = 2'(id); req_wr = wr[0]; req_bg = bg[0];
    req_bank = 2'(bank); req_row = 8'(row);
    at = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic int next_slot(input int r, input int c);
    int b = ((c + 2 + SL - 1) / SL) * SL;
    while (((b / SL) % NREQ) != r) b += SL;
    return b;
  endfunction

  function automatic int find_at(input int c);
    for (int i = 0; i < l_n; i++) if (l_cyc[i] == c) return i;
    return -1;
  endfunction

  task automatic expect_served(input int b, input int id, input int date, input int wr,
                               input int bg, input int bank, input int row, input string tag);
    int offs [3];
    int cmds [3];
    int ex;
    offs[0] = 0; offs[1] = ACTD; offs[2] = COLD;
    cmds[0] = 1; cmds[1] = 2; cmds[2] = wr ? 4 : 3;
    ex = pack(id, date, wr, bg, bank, row);
    wait_cyc(b + COLD + 1);
    for (int k = 0; k < 3; k++) begin
      int idx = find_at(b + offs[k]);
      chk(idx >= 0 && l_cmd[idx] == cmds[k], "R3/R9", $sformatf("command at cycle %0d", b + offs[k]),
          (idx >= 0) ? l_cmd[idx] : 0, cmds[k]);
      chk(idx >= 0 && l_fld[idx] == ex, tag, $sformatf("fields at cycle %0d", b + offs[k]),
          (idx >= 0) ? l_fld[idx] : 0, ex);
    end
  endtask

  task automatic check_quiet(input int a, input int z, input string tag);
    int n = 0;
    wait_cyc(z + 1);
    for (int i = 0; i < l_n; i++) if (l_cyc[i] >= a && l_cyc[i] <= z) n++;
    chk(n == 0, tag, $sformatf("commands in cycles %0d..%0d", a, z), n, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(cmd == 3'd0 && {c_id, c_date, c_wr, c_bg, c_bank, c_row} == '0, "R1", "output in reset",
        int'(cmd), 0);
    rst_n = 1'b1;
    #1;
    chk(cmd == 3'd0 && {c_id, c_date, c_wr, c_bg, c_bank, c_row} == '0, "R1", "output at cycle 0",
        int'(cmd), 0);
  endtask

  task automatic t_single;
    int at, b;
    wait_cyc(2);
    push(1, 0, 1, 1, 'h11, at);
    b = next_slot(1, at);
    chk(b == SL, "R2", "first slot of requestor 1", b, SL);
    expect_served(b, 1, at, 0, 1, 1, 'h11, "R2/R8");
    check_quiet(0, SL - 1, "R4");
    check_quiet(b + COLD + 1, 4 * SL - 1, "R4");
  endtask

  task automatic t_order;
    int a0, a1, b;
    push(2, 1, 0, 2, 'h21, a0);
    push(2, 0, 0, 2, 'h22, a1);
    b = next_slot(2, a0);
    expect_served(b, 2, a0, 1, 0, 2, 'h21, "R5");
    check_quiet(b + SL, b + 2 * SL - 1, "R4");
    expect_served(b + PER, 2, a1, 0, 0, 2, 'h22, "R5");
  endtask

  task automatic t_elig;
    int a0, a1, b0;
    b0 = next_slot(0, cyc + 1);
    wait_cyc(b0 - 1);
    push(0, 0, 0, 0, 'h31, a0);
    wait_cyc(b0 + SL - 2);
    push(1, 1, 1, 1, 'h32, a1);
    check_quiet(b0, b0 + SL - 1, "R6");
    expect_served(b0 + SL, 1, a1, 1, 1, 1, 'h32, "R6");
    expect_served(b0 + PER, 0, a0, 0, 0, 0, 'h31, "R6");
  endtask

  task automatic t_full;
    int at [5];
    int b;
    b = next_slot(2, cyc);
    wait_cyc(b);
    for (int i = 0; i < 5; i++) push(2, 0, 0, 2, 'h40 + i, at[i]);
    for (int i = 0; i < DEPTH; i++)
      expect_served(b + PER * (i + 1), 2, at[i], 0, 0, 2, 'h40 + i, "R5/R7");
    check_quiet(b + PER * (DEPTH + 1), b + PER * (DEPTH + 1) + SL - 1, "R7");
  endtask

  task automatic t_badid;
    int at;
    push(3, 0, 1, 3, 'h55, at);
    check_quiet(at + 1, at + PER + SL, "R7");
  endtask

  task automatic t_all;
    int at [NREQ];
    int b [NREQ];
    int first;
    for (int r = 0; r < NREQ; r++) push(r, r & 1, r & 1, r, 'h60 + r, at[r]);
    for (int r = 0; r < NREQ; r++) b[r] = next_slot(r, at[r]);
    first = ((at[0] + SL) / SL) * SL;
    for (int s = 0; s <= NREQ + 1; s++) begin
      int bs = first + s * SL;
      int o = (bs / SL) % NREQ;
      if (bs == b[o]) expect_served(bs, o, at[o], o & 1, o & 1, o, 'h60 + o, "R2/R5");
    end
  endtask

  task automatic t_timing;
    int v_rrd = 0, v_rc = 0, v_rp = 0, v_rcd = 0, v_ras = 0, v_ccd = 0, v_wtr = 0, v_rtw = 0, v_faw = 0;
    for (int i = 0; i < l_n; i++) begin
      int na = 0;
      for (int j = i + 1; j < l_n; j++) begin
        int g = l_cyc[j] - l_cyc[i];
        bit sb = (l_bk[i] == l_bk[j]);
        int ci = l_cmd[i], cj = l_cmd[j];
        bit coli = (ci == 3 || ci == 4), colj = (cj == 3 || cj == 4);
        if (ci == 2 && cj == 2) begin
          if (g < TRRD) v_rrd++;
          if (sb && g < TRC) v_rc++;
        end
        if (ci == 1 && cj == 2 && sb && g < TRP) v_rp++;
        if (ci == 2 && colj && sb && g < TRCD) v_rcd++;
        if (ci == 2 && cj == 1 && sb && g < TRAS) v_ras++;
        if (coli && colj && g < TCCD) v_ccd++;
        if (ci == 4 && cj == 3 && g < TWTR + TWL + TBURST) v_wtr++;
        if (ci == 3 && cj == 4 && g < TRTW) v_rtw++;
        if (ci == 2 && cj == 2 && g < TFAW) na++;
      end
      if (l_cmd[i] == 2 && na >= 3) v_faw++;
    end
    chk(l_n > 20, "R10", "trace length", l_n, 21);
    chk(v_rp == 0,  "R10", "tRP violations",  v_rp, 0);
    chk(v_rcd == 0, "R10", "tRCD violations", v_rcd, 0);
    chk(v_ras == 0, "R10", "tRAS violations", v_ras, 0);
    chk(v_rc == 0,  "R10", "tRC violations",  v_rc, 0);
    chk(v_rrd == 0, "R10", "tRRD violations", v_rrd, 0);
    chk(v_ccd == 0, "R10", "tCCD violations", v_ccd, 0);
    chk(v_wtr == 0, "R10", "tWTR violations", v_wtr, 0);
    chk(v_rtw == 0, "R10", "tRTW violations", v_rtw, 0);
    chk(v_faw == 0, "R10", "tFAW violations", v_faw, 0);
    chk(nop_bad == 0, "R4", "NOP cycles with nonzero fields", nop_bad, 0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_order();
    t_elig();
    t_full();
    t_badid();
    t_all();
    t_timing();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule